// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches the upper four pins of an 8-bit bidirectional general-purpose port and raises a sticky change flag when any of them, while configured as an input, differs from a reference snapshot. The snapshot is not refreshed every cycle. It is reloaded only when software reads or writes the port. A key press on a polled keypad therefore stays visible until software touches the port.

Pin values enter through a synchronizer. Each watched input pin is compared with its snapshot bit, and the per-pin mismatches are ORed into one condition. That condition sets the flag, which software clears with a strobe. While the condition persists, a clear cannot win, so the flag comes straight back. A separate wake request follows the live mismatch condition one cycle late. It is meant for a sleep controller and drops as soon as a port access refreshes the snapshot, even though the flag stays set. No enable of any kind gates the flag.

Top module: `port_change_watch`

## Requirements
- R1: A synchronous active-high reset clears change_flag and wake_req. While reset is held, the snapshot keeps loading the synchronized pin state, so steady pins cause no change report after reset is released.
- R2: A change on a watched pin (bits 7:4) whose direction bit is 1 (input) sets change_flag and wake_req on the third rising clock edge after the change. Two of those edges are spent in the synchronizer and one in the output register.
- R3: Changes on pins 3:0 never affect change_flag or wake_req.
- R4: A watched pin whose direction bit is 0 (output) is excluded from the comparison. If that pin is later switched to input while it differs from its snapshot bit, the mismatch is reported on the next clock edge.
- R5: Without a mismatch, change_flag holds its value until flag_clr is high at a clock edge, and is 0 after that edge.
- R6: While a mismatch persists, change_flag is set at every edge. When flag_clr and the set condition occur at the same edge, the flag stays 1.
- R7: port_rd high at an edge loads the synchronized pins into the snapshot, which ends the mismatch from the following edge on.
- R8: port_wr high at an edge refreshes the snapshot in the same way as port_rd.
- R9: wake_req equals the mismatch condition registered one edge earlier. It falls one edge after a refreshing access, even while change_flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 8 | Raw port pin levels, asynchronous to clk |
| dir_in | input | 8 | Per-pin direction, 1 = input, 0 = output |
| port_rd | input | 1 | Port read strobe, refreshes the snapshot |
| port_wr | input | 1 | Port write strobe, refreshes the snapshot |
| flag_clr | input | 1 | Software clear of the change flag |
| change_flag | output | 1 | Sticky port change flag |
| wake_req | output | 1 | Registered live mismatch, for wake from sleep |

## Verification
A pin change is due at the outputs on the third rising edge after it is driven. A direction change, strobe or clear is due on the first edge after it is driven. The bench drives every input on the falling edge. Each expected value is pushed into the scoreboard queue just before the edge it belongs to, and the monitor compares the outputs 2 ns after that edge. This keeps every comparison aligned to the cycle counted from the requirement. Waits of several cycles with an expected 0 cover the ignored-pin cases: the output would have risen within those cycles if the pin had been compared.

// File: rtl/port_change_pkg.sv
package port_change_pkg;

    // Direction encoding of one port pin
    typedef enum logic {
        PIN_OUTPUT = 1'b0,
        PIN_INPUT  = 1'b1
    } pin_dir_e;

    // Registered outputs of the flag stage
    typedef struct packed {
        logic flag;
        logic wake;
    } change_state_t;

    localparam change_state_t CHANGE_IDLE = '{flag: 1'b0, wake: 1'b0};

    // Next flag value: a set condition beats a clear in the same cycle
    function automatic logic next_flag(input logic cur, input logic set_c, input logic clr_c);
        if (set_c)
            return 1'b1;
        else if (clr_c)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // The chain is not reset: it must keep sampling while reset is held
    always_ff @(posedge clk) begin
        stage_q[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pcw_snapshot.sv
module pcw_snapshot
    import port_change_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] dir_w,
    input  logic             access,
    output logic [WIDTH-1:0] mismatch
);
    logic [WIDTH-1:0] ref_q;

    // Reference follows the pins during reset, then only on port access
    always_ff @(posedge clk) begin
        if (rst || access)
            ref_q <= pin_s;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
            assign mismatch[i] = (pin_dir_e'(dir_w[i]) == PIN_INPUT) && (pin_s[i] != ref_q[i]);
        end
    endgenerate

    // R7 / R8: an access loads the snapshot with the synchronized pins
    a_r7_refresh_loads: assert property (@(posedge clk) disable iff (rst)
        access |=> ref_q == $past(pin_s));

    // R7: without an access the snapshot holds
    a_r7_snapshot_holds: assert property (@(posedge clk) disable iff (rst)
        !access |=> $stable(ref_q));
endmodule

// File: rtl/pcw_flag.sv
module pcw_flag
    import port_change_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          set_c,
    input  logic          clr_c,
    output change_state_t st_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CHANGE_IDLE;
        end else begin
            st_q.flag <= next_flag(st_q.flag, set_c, clr_c);
            st_q.wake <= set_c;
        end
    end

    // R6: a live mismatch always leaves the flag set, clear or not
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_c |=> st_q.flag);

    // R5: a clear with no mismatch empties the flag
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_c && !set_c) |=> !st_q.flag);

    // R5: with neither event the flag holds
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr_c && !set_c) |=> $stable(st_q.flag));

    // R9: wake follows the condition of the previous edge
    a_r9_wake_tracks: assert property (@(posedge clk) disable iff (rst)
        !set_c |=> !st_q.wake);
endmodule

// File: rtl/port_change_watch.sv
module port_change_watch
    import port_change_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int WATCH_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_async,
    input  logic [PORT_W-1:0] dir_in,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic              flag_clr,
    output logic              change_flag,
    output logic              wake_req
);
    localparam int WATCH_LO = PORT_W - WATCH_W;

    logic [WATCH_W-1:0] pin_s;
    logic [WATCH_W-1:0] mismatch;
    logic               any_change;
    change_state_t      st;

    // Low pins are not watched (R3)
    logic unused_low;
    assign unused_low = ^{pin_async[WATCH_LO-1:0], dir_in[WATCH_LO-1:0]};

    pcw_sync #(
        .WIDTH  (WATCH_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .d_async (pin_async[PORT_W-1:WATCH_LO]),
        .q_sync  (pin_s)
    );

    pcw_snapshot #(
        .WIDTH (WATCH_W)
    ) u_snap (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (pin_s),
        .dir_w    (dir_in[PORT_W-1:WATCH_LO]),
        .access   (port_rd || port_wr),
        .mismatch (mismatch)
    );

    assign any_change = |mismatch;

    pcw_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_c (any_change),
        .clr_c (flag_clr),
        .st_q  (st)
    );

    assign change_flag = st.flag;
    assign wake_req    = st.wake;

    // R9: a wake request is never raised without the flag
    a_r9_wake_implies_flag: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> change_flag);

    // R1: outputs are idle on the first edge out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!change_flag && !wake_req));
endmodule

// File: tb/tb_port_change_watch.sv
module tb_port_change_watch;

    typedef struct {
        logic  flag;
        logic  wake;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_async = 8'hA5;
    logic [7:0] dir_in = 8'hF0;
    logic       port_rd = 1'b0;
    logic       port_wr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       change_flag;
    logic       wake_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    port_change_watch dut (
        .clk         (clk),
        .rst         (rst),
        .pin_async   (pin_async),
        .dir_in      (dir_in),
        .port_rd     (port_rd),
        .port_wr     (port_wr),
        .flag_clr    (flag_clr),
        .change_flag (change_flag),
        .wake_req    (wake_req)
    );

    // Driver: expectation for the coming edge, then move to the next falling edge
    task automatic cyc(input logic f, input logic w, input string req);
        exp_t e;
        e.flag = f;
        e.wake = w;
        e.req  = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare just after each edge that has an expectation
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (change_flag !== e.flag || wake_req !== e.wake) begin
                n_bad++;
                $display("FAIL %s: flag/wake actual %b/%b expected %b/%b at %0t",
                         e.req, change_flag, wake_req, e.flag, e.wake, $time);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with steady nonzero pins
        for (int i = 0; i < 5; i++) cyc(0, 0, "R1 in reset");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) cyc(0, 0, "R1 after reset");

        // R3: low pins change
        pin_async = 8'hA0;
        for (int i = 0; i < 4; i++) cyc(0, 0, "R3 low pins");
        pin_async = 8'hAF;
        for (int i = 0; i < 4; i++) cyc(0, 0, "R3 low pins");

        // R4: pin 7 as output toggles
        dir_in = 8'h70;
        pin_async = 8'h2F;
        for (int i = 0; i < 4; i++) cyc(0, 0, "R4 output pin");
        pin_async = 8'hAF;
        for (int i = 0; i < 3; i++) cyc(0, 0, "R4 output pin");
        dir_in = 8'hF0;
        cyc(0, 0, "R4 restore");

        // R2: pin 5 changes
        pin_async = 8'h8F;
        cyc(0, 0, "R2 sync 1");
        cyc(0, 0, "R2 sync 2");
        cyc(1, 1, "R2 flag due");
        cyc(1, 1, "R2 persists");

        // R6: clear against live mismatch
        flag_clr = 1'b1;
        cyc(1, 1, "R6 set wins");
        flag_clr = 1'b0;
        cyc(1, 1, "R6 set again");

        // R7: read refreshes
        port_rd = 1'b1;
        cyc(1, 1, "R7 read edge");
        port_rd = 1'b0;
        cyc(1, 0, "R7 R9 wake drops");
        cyc(1, 0, "R5 flag holds");

        // R5: clear
        flag_clr = 1'b1;
        cyc(0, 0, "R5 clear");
        flag_clr = 1'b0;
        cyc(0, 0, "R5 stays clear");

        // R8: pin 6 changes, write refreshes
        pin_async = 8'hCF;
        cyc(0, 0, "R2 sync 1");
        cyc(0, 0, "R2 sync 2");
        cyc(1, 1, "R2 pin6");
        port_wr = 1'b1;
        cyc(1, 1, "R8 write edge");
        port_wr = 1'b0;
        cyc(1, 0, "R8 mismatch ended");
        flag_clr = 1'b1;
        cyc(0, 0, "R5 clear");
        flag_clr = 1'b0;

        // R4: pin 4 differs while output, then becomes input
        dir_in = 8'hE0;
        pin_async = 8'hDF;
        for (int i = 0; i < 3; i++) cyc(0, 0, "R4 masked");
        dir_in = 8'hF0;
        cyc(1, 1, "R4 reenter input");
        port_rd = 1'b1;
        cyc(1, 1, "R7 read edge");
        port_rd = 1'b0;
        cyc(1, 0, "R9 wake drops");
        flag_clr = 1'b1;
        cyc(0, 0, "R5 clear");
        flag_clr = 1'b0;

        // R2: all watched pins change at once
        pin_async = 8'h2F;
        cyc(0, 0, "R2 sync 1");
        cyc(0, 0, "R2 sync 2");
        cyc(1, 1, "R2 all pins");

        // R1: reset while flagged
        rst = 1'b1;
        cyc(0, 0, "R1 reset clears");
        for (int i = 0; i < 3; i++) cyc(0, 0, "R1 in reset");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 0, "R1 after reset");

        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule